// File: doc/BRIEF.md
# Channel-Grouped 3x3 Convolution Engine

This block is the multiply-accumulate datapath of a CNN accelerator. In each accepted cycle it takes one 3x3 input window for each of four channels, multiplies it tap by tap against a held set of four 3x3 filters, and reduces the 36 rounded products to one group sum. A layer whose input-channel count exceeds four is processed as a sequence of channel groups. For every output pixel of the first group, the group sum is stored in an external partial-sum SRAM at that pixel's index. Each later group reads the stored value back and adds its own sum to it. The last group forwards the finished value downstream instead of writing it.

A layer begins with a start pulse that carries the group count and the number of output pixels per group. The filter set loads through a separate strobe and stays in place across every window of a group. A new set can load in the same cycle as the last window of the previous group, so windows can arrive back to back across a group boundary. The SRAM returns read data one cycle after the read. The engine forwards a result that is still being written, so the read-add-write loop keeps up with one window per cycle even when a group has a single pixel.

Top module: `conv_group_engine`

## Requirements
- R1: After reset, busy, done, out_valid, ps_rd_en and ps_wr_en are all low.
- R2: Every product of a 16-bit signed sample and a 16-bit signed weight is rounded as floor((p + 128) / 256). It is then clamped to the 20-bit signed range [-524288, 524287]. Channel c, tap k sits at bits [(9c+k)*16 +: 16] of both win_data and wgt_in.
- R3: A group sum is the total of the 36 clamped terms, clamped to the 20-bit signed range.
- R4: In the first group the engine issues no read. One cycle after a window is accepted it writes the group sum to the SRAM at the address equal to that window's pixel index. Pixels are numbered 0 upward within each group.
- R5: In a later group, the read is issued in the acceptance cycle at the pixel index. One cycle later the clamped sum of the group sum and the stored value is written back, or forwarded if this is the last group.
- R6: In the last group, out_valid is high one cycle after acceptance and carries out_data and out_pix. That window causes no SRAM write.
- R7: When the previous cycle's write targets the address being read, the engine uses the value just written instead of the SRAM read data.
- R8: Weights change only on wgt_load. A window accepted in the same cycle as wgt_load uses the weights held before the load.
- R9: done pulses for one cycle, one cycle after the final out_valid of the layer. busy is low by then, and windows presented while busy is low produce no read, write or output.
- R10: A group count or pixel count of 0 at start is treated as 1.
- R11: Accumulation across groups saturates at the 20-bit limits and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a layer |
| cfg_groups | input | GW | Channel groups in the layer |
| cfg_pixels | input | AW+1 | Output pixels per group |
| wgt_load | input | 1 | Loads the filter set |
| wgt_in | input | 576 | Four 3x3 filters, 16-bit taps |
| win_valid | input | 1 | Window present |
| win_data | input | 576 | Four 3x3 windows, 16-bit taps |
| busy | output | 1 | Layer in progress, windows accepted |
| ps_rd_en | output | 1 | Partial-sum read |
| ps_rd_addr | output | AW | Read address |
| ps_rd_data | input | PW | Read data, one cycle after the read |
| ps_wr_en | output | 1 | Partial-sum write |
| ps_wr_addr | output | AW | Write address |
| ps_wr_data | output | PW | Write data |
| out_valid | output | 1 | Finished sum present |
| out_pix | output | AW | Pixel index of the finished sum |
| out_data | output | PW | Finished sum |
| done | output | 1 | Layer finished |

## Verification
The in-module assertions check the timing relations on every cycle. They confirm that an output follows an acceptance, that a read is followed by a write or an output, and that done follows the final output while the engine is idle. They also confirm that two non-negative operands never accumulate into a negative value. The arithmetic itself can only be shown by the bench scenarios: rounding, per-term and per-group clamping, and which group's weights a window uses. The same holds for forwarding on single-pixel groups and for the handling of zero counts. The bench sweeps group counts and pixel counts, drives both random and saturating operands, and compares every write and output against sums it computes itself.

// File: rtl/conv_group_engine.sv
module conv_group_engine #(
  parameter int DW   = 16,
  parameter int PW   = 20,
  parameter int NCH  = 4,
  parameter int FRAC = 8,
  parameter int AW   = 8,
  parameter int GW   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [GW-1:0]          cfg_groups,
  input  logic [AW:0]            cfg_pixels,
  input  logic                   wgt_load,
  input  logic [NCH*9*DW-1:0]    wgt_in,
  input  logic                   win_valid,
  input  logic [NCH*9*DW-1:0]    win_data,
  output logic                   busy,
  output logic                   ps_rd_en,
  output logic [AW-1:0]          ps_rd_addr,
  input  logic [PW-1:0]          ps_rd_data,
  output logic                   ps_wr_en,
  output logic [AW-1:0]          ps_wr_addr,
  output logic [PW-1:0]          ps_wr_data,
  output logic                   out_valid,
  output logic [AW-1:0]          out_pix,
  output logic [PW-1:0]          out_data,
  output logic                   done
);
  localparam int KK    = 9;
  localparam int NT    = NCH * KK;
  localparam int WIN_W = NT * DW;
  localparam int PRW   = 2 * DW;
  localparam int SHW   = PRW - FRAC + 1;
  localparam int SW    = PW + $clog2(NT) + 1;
  localparam logic [PW-1:0] PMAXV = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] PMINV = {1'b1, {(PW-1){1'b0}}};
  localparam logic signed [SW-1:0] HI_S = {{(SW-PW){1'b0}}, PMAXV};
  localparam logic signed [SW-1:0] LO_S = {{(SW-PW){1'b1}}, PMINV};

  function automatic logic [PW-1:0] clip(input logic signed [SW-1:0] v);
    if (v > HI_S)      clip = PMAXV;
    else if (v < LO_S) clip = PMINV;
    else               clip = v[PW-1:0];
  endfunction

  function automatic logic signed [SW-1:0] sx(input logic [PW-1:0] v);
    sx = {{(SW-PW){v[PW-1]}}, v};
  endfunction

  logic [WIN_W-1:0] wgt_q;
  logic [PW-1:0]    term [NT];
  logic signed [SW-1:0] tsum;
  logic [PW-1:0]    gsum;

  logic          ld_busy;
  logic [GW-1:0] grp, ngrp;
  logic [AW:0]   npix;
  logic [AW-1:0] pix;
  logic          accept, last_pix, last_grp, fwd;

  logic          s1_v, s1_first, s1_lastg, s1_end, s1_fwd;
  logic [AW-1:0] s1_pix;
  logic [PW-1:0] s1_sum, s1_fdat, base, acc;

  always_ff @(posedge clk)
    if (!rst_n)        wgt_q <= '0;
    else if (wgt_load) wgt_q <= wgt_in;

  for (genvar t = 0; t < NT; t++) begin : g_tap
    logic signed [PRW-1:0] prod;
    logic signed [PRW:0]   rnd;
    logic [SHW-1:0]        shv;
    assign prod = $signed(win_data[t*DW +: DW]) * $signed(wgt_q[t*DW +: DW]);
    assign rnd  = {prod[PRW-1], prod} + {{SHW{1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    assign shv  = rnd[PRW:FRAC];
    assign term[t] = clip({{(SW-SHW){shv[SHW-1]}}, shv});
  end

  always_comb begin
    tsum = '0;
    for (int t = 0; t < NT; t++) tsum = tsum + sx(term[t]);
  end
  assign gsum = clip(tsum);

  assign busy     = ld_busy;
  assign accept   = win_valid && ld_busy && !start;
  assign last_pix = ({1'b0, pix} == npix - 1'b1);
  assign last_grp = (grp == ngrp - 1'b1);

  assign ps_rd_en   = accept && (grp != '0);
  assign ps_rd_addr = pix;
  assign fwd        = ps_wr_en && (ps_wr_addr == pix);

  assign base = s1_first ? '0 : (s1_fwd ? s1_fdat : ps_rd_data);
  assign acc  = clip(sx(s1_sum) + sx(base));

  assign ps_wr_en   = s1_v && !s1_lastg;
  assign ps_wr_addr = s1_pix;
  assign ps_wr_data = acc;
  assign out_valid  = s1_v && s1_lastg;
  assign out_pix    = s1_pix;
  assign out_data   = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_busy <= 1'b0; grp <= '0; ngrp <= '0; npix <= '0; pix <= '0;
      s1_v <= 1'b0; s1_first <= 1'b0; s1_lastg <= 1'b0; s1_end <= 1'b0;
      s1_fwd <= 1'b0; s1_pix <= '0; s1_sum <= '0; s1_fdat <= '0;
      done <= 1'b0;
    end else begin
      if (start) begin
        ld_busy <= 1'b1;
        grp     <= '0;
        pix     <= '0;
        ngrp    <= (cfg_groups == '0) ? GW'(1) : cfg_groups;
        npix    <= (cfg_pixels == '0) ? (AW+1)'(1) : cfg_pixels;
      end else if (accept) begin
        if (last_pix) begin
          pix <= '0;
          if (last_grp) ld_busy <= 1'b0;
          else          grp <= grp + 1'b1;
        end else begin
          pix <= pix + 1'b1;
        end
      end
      s1_v <= accept;
      if (accept) begin
        s1_first <= (grp == '0);
        s1_lastg <= last_grp;
        s1_end   <= last_grp && last_pix;
        s1_pix   <= pix;
        s1_sum   <= gsum;
        s1_fwd   <= fwd;
        s1_fdat  <= ps_wr_data;
      end
      done <= s1_v && s1_end;
    end
  end

  a_r6_out_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(win_valid));
  a_r5_read_then_result: assert property (@(posedge clk) disable iff (!rst_n)
    ps_rd_en |=> (ps_wr_en || out_valid));
  a_r9_done_after_out: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_sum[PW-1] && !base[PW-1]) |-> !acc[PW-1]);
endmodule

// File: tb/conv_group_engine_tb.sv
module conv_group_engine_tb;
  localparam int AW = 8, GW = 6, PW = 20, WW = 576;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wgt_load = 1'b0, win_valid = 1'b0;
  logic [GW-1:0] cfg_groups = '0;
  logic [AW:0]   cfg_pixels = '0;
  logic [WW-1:0] wgt_in = '0, win_data = '0;
  logic busy, ps_rd_en, ps_wr_en, out_valid, done;
  logic [AW-1:0] ps_rd_addr, ps_wr_addr, out_pix;
  logic [PW-1:0] ps_rd_data, ps_wr_data, out_data;

  always #2 clk = ~clk;

  conv_group_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_groups(cfg_groups),
    .cfg_pixels(cfg_pixels), .wgt_load(wgt_load), .wgt_in(wgt_in),
    .win_valid(win_valid), .win_data(win_data), .busy(busy),
    .ps_rd_en(ps_rd_en), .ps_rd_addr(ps_rd_addr), .ps_rd_data(ps_rd_data),
    .ps_wr_en(ps_wr_en), .ps_wr_addr(ps_wr_addr), .ps_wr_data(ps_wr_data),
    .out_valid(out_valid), .out_pix(out_pix), .out_data(out_data), .done(done));

  logic [PW-1:0] mem [256];
  logic [PW-1:0] rd_q = '0;
  assign ps_rd_data = rd_q;
  always @(posedge clk) begin
    if (ps_rd_en) rd_q <= mem[ps_rd_addr];
    if (ps_wr_en) mem[ps_wr_addr] <= ps_wr_data;
  end

  int nchk = 0, nfail = 0;
  int bw [3][36];
  int bd [3][4][36];
  int exp_part [3][4];
  int exp_fin [4];
  int cur_np = 1, wcnt = 0, ocnt = 0, dcnt = 0, idle_bad = 0;
  bit idle_mode = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rsat(input longint v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return int'(v);
  endfunction

  function automatic int gsum_ref(input int g, input int p);
    longint s = 0;
    for (int t = 0; t < 36; t++) begin
      longint pr = longint'(bd[g][p][t]) * longint'(bw[g][t]);
      s += rsat((pr + 128) >>> 8);
    end
    return rsat(s);
  endfunction

  function automatic logic [WW-1:0] pack_w(input int g);
    logic [WW-1:0] v;
    for (int t = 0; t < 36; t++) v[t*16 +: 16] = 16'(bw[g][t]);
    return v;
  endfunction

  function automatic logic [WW-1:0] pack_d(input int g, input int p);
    logic [WW-1:0] v;
    for (int t = 0; t < 36; t++) v[t*16 +: 16] = 16'(bd[g][p][t]);
    return v;
  endfunction

  function automatic int sgn20(input logic [PW-1:0] v);
    return int'($signed(v));
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (idle_mode && (out_valid || ps_wr_en || ps_rd_en)) idle_bad++;
    if (out_valid) begin
      chk(sgn20(out_data) == exp_fin[out_pix], "R6 final sum", sgn20(out_data), exp_fin[out_pix]);
      ocnt++;
    end
    if (ps_wr_en) begin
      chk(int'(ps_wr_addr) == wcnt % cur_np, "R4 write address", int'(ps_wr_addr), wcnt % cur_np);
      chk(sgn20(ps_wr_data) == exp_part[wcnt / cur_np][ps_wr_addr], "R5 R7 partial sum",
          sgn20(ps_wr_data), exp_part[wcnt / cur_np][ps_wr_addr]);
      wcnt++;
    end
    if (done) dcnt++;
  end

  task automatic run_layer(input int ng, input int np, input int cfg_g, input int mode);
    for (int g = 0; g < ng; g++) begin
      for (int t = 0; t < 36; t++) begin
        case (mode)
          1: bw[g][t] = 32767;
          2: bw[g][t] = -32768;
          3: bw[g][t] = int'($urandom_range(0, 600)) - 300;
          default: bw[g][t] = int'($urandom_range(0, 4000)) - 2000;
        endcase
        for (int p = 0; p < np; p++)
          bd[g][p][t] = (mode == 1 || mode == 2) ? 32767 :
                        (mode == 3) ? int'($urandom_range(0, 600)) - 300 :
                        int'($urandom_range(0, 4000)) - 2000;
      end
    end
    for (int p = 0; p < np; p++) begin
      int a = gsum_ref(0, p);
      for (int g = 1; g < ng; g++) begin
        exp_part[g-1][p] = a;
        a = rsat(longint'(a) + gsum_ref(g, p));
      end
      exp_fin[p] = a;
    end
    cur_np = np; wcnt = 0; ocnt = 0; dcnt = 0;
    @(posedge clk); #1 wgt_load = 1; wgt_in = pack_w(0);
    @(posedge clk); #1 wgt_load = 0; start = 1; cfg_groups = GW'(cfg_g); cfg_pixels = (AW+1)'(np);
    @(posedge clk); #1 start = 0;
    for (int g = 0; g < ng; g++)
      for (int p = 0; p < np; p++) begin
        win_valid = 1; win_data = pack_d(g, p);
        if (p == np - 1 && g < ng - 1) begin wgt_load = 1; wgt_in = pack_w(g + 1); end
        else wgt_load = 0;
        @(posedge clk); #1;
      end
    win_valid = 0; wgt_load = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(ocnt == np, "R6 output count", ocnt, np);
    chk(wcnt == (ng - 1) * np, "R4 write count", wcnt, (ng - 1) * np);
    chk(dcnt == 1, "R9 done pulses", dcnt, 1);
    chk(busy == 0, "R9 idle after layer", int'(busy), 0);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !out_valid && !ps_wr_en && !ps_rd_en, "R1 reset state",
        int'({busy, done, out_valid, ps_wr_en, ps_rd_en}), 0);
    // R2 R3 R5 R8: sweep of group and pixel counts, moderate random operands
    for (int ng = 1; ng <= 3; ng++)
      for (int k = 0; k < 3; k++) begin
        int np = (k == 0) ? 1 : (k == 1) ? 3 : 4;
        run_layer(ng, np, ng, 0);
      end
    // R7 single-pixel groups back to back with small operands
    run_layer(3, 1, 3, 3);
    // R2 R11 positive and negative saturation
    run_layer(3, 2, 3, 1);
    run_layer(2, 3, 2, 2);
    // R10 zero group count behaves as one group
    run_layer(1, 2, 0, 0);
    // R9 windows after the layer are ignored
    idle_bad = 0; idle_mode = 1;
    @(posedge clk); #1 win_valid = 1; win_data = pack_d(0, 0);
    repeat (3) @(posedge clk);
    #1 win_valid = 0;
    repeat (3) @(posedge clk);
    #1 idle_mode = 0;
    chk(idle_bad == 0, "R9 ignored windows", idle_bad, 0);
    chk(ocnt == 2, "R9 no extra outputs", ocnt, 2);
    finish_up();
  end
endmodule